// File: doc/BRIEF.md
# Register Rename Map with Free Register Pool

This block renames one instruction per cycle onto a physical register file that is larger than the architectural one. A mapping table holds the current physical register for every architectural register. For each incoming instruction, the block looks up the physical names of its two source registers. If the instruction writes a result, the block takes a fresh physical register from the head of a free-register FIFO and points the destination's table entry at it. Because every result gets a new physical home, write-after-read and write-after-write conflicts disappear, and only true read-after-write links remain.

The block also reports the physical register that the destination was mapped to before the update. Commit logic returns that register later through a separate free-return port, which appends it to the tail of the FIFO.

Instructions enter and leave on a valid/ready stream. Renamed results leave in the same cycle the instruction is accepted. An upstream instruction is accepted only when both of these hold:
- the downstream stage is ready;
- the instruction writes no register, or the free FIFO holds at least one register.

`out_valid` never depends on `out_ready`. An offered instruction must be held stable until it is accepted.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free FIFO holds physical registers ARCH_REGS up to PHYS_REGS-1, handed out in ascending order.
- R2: The physical sources of an instruction come from the table as it stood before that instruction's own update, even when a source equals the destination.
- R3: An accepted instruction with `in_has_dst`=1 gets `out_pdst` equal to the FIFO head. The table entry for `in_dst` then holds that register, so later readers of `in_dst` see it.
- R4: For an instruction with a destination, `out_pold` equals the physical register that `in_dst` was mapped to just before the update.
- R5: An instruction with `in_has_dst`=0 consumes no FIFO entry and leaves the table unchanged. It drives `out_pdst` and `out_pold` to zero.
- R6: When the FIFO is empty, an instruction with a destination is stalled: `in_ready`=0 and `out_valid`=0, and nothing is updated. An instruction without a destination still passes while the FIFO is empty.
- R7: A register offered with `free_valid`=1 is appended at the FIFO tail and handed out after all registers already queued. A return and an allocation in the same cycle both take effect. A return made during a stall does not release that same cycle's stall.
- R8: `out_valid` = `in_valid` and not stalled. `in_ready` = `out_ready` and not stalled. With `out_ready`=0, no instruction is consumed and no state changes.
- R9: The sequence (r1←r2), (r2←r0), (r1←r2) is renamed as follows, using a FIFO that starts at 8, 9, 10:
  - the first instruction reads P2 and writes P8, with old mapping P1;
  - the second reads P0 and writes P9, with old mapping P2;
  - the third reads P9 and writes P10, with old mapping P8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_src_a | input | $clog2(ARCH_REGS) | First architectural source |
| in_src_b | input | $clog2(ARCH_REGS) | Second architectural source |
| in_dst | input | $clog2(ARCH_REGS) | Architectural destination |
| in_has_dst | input | 1 | Instruction writes a register |
| out_valid | output | 1 | Renamed instruction available |
| out_ready | input | 1 | Downstream can take a renamed instruction |
| out_psrc_a | output | $clog2(PHYS_REGS) | Physical first source |
| out_psrc_b | output | $clog2(PHYS_REGS) | Physical second source |
| out_pdst | output | $clog2(PHYS_REGS) | Newly allocated physical destination |
| out_pold | output | $clog2(PHYS_REGS) | Previous physical mapping of the destination |
| out_has_dst | output | 1 | Copy of in_has_dst |
| free_valid | input | 1 | Return a physical register to the FIFO |
| free_preg | input | $clog2(PHYS_REGS) | Physical register being returned |

## Verification
The hardest situation to reach from the ports is an empty free FIFO meeting a same-cycle return while an allocating instruction waits. The stimulus first spends every free register through a chain of allocations. It then offers a destination-writing instruction together with a returned register. The instruction must stay stalled for that cycle and take the returned register on the next one. A later cycle with one register left combines a return with an allocation, which checks that pop and push both land and that FIFO order is kept.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_ARCH_REGS = 8;
  localparam int unsigned DEF_PHYS_REGS = 16;

  // circular pointer step for a FIFO of arbitrary depth
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_phys,
  output logic [PW-1:0] rd_b_phys,
  output logic [PW-1:0] rd_d_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_phys
);
  logic [PW-1:0] entry_q [ARCH_REGS];

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= PW'(g);
      end else if (wr_en && (wr_idx == AW'(g))) begin
        entry_q[g] <= wr_phys;
      end
    end
  end

  // reads see the table before this cycle's write
  always_comb begin
    rd_a_phys = entry_q[rd_a_idx];
    rd_b_phys = entry_q[rd_b_idx];
    rd_d_phys = entry_q[rd_d_idx];
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int unsigned BASE  = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 4,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  input  logic          pop,
  output logic [PW-1:0] pop_data,
  output logic [CW-1:0] count
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= PW'(BASE + i);
    end else if (push) begin
      slot_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      if (pop)  head_q <= IW'(rename_pkg::wrap_inc(int'(head_q), DEPTH));
      if (push) tail_q <= IW'(rename_pkg::wrap_inc(int'(tail_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pop_data = slot_q[head_q];
  assign count    = cnt_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int unsigned ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
  parameter int unsigned PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned FL_DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int unsigned CW = $clog2(FL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  input  logic          in_has_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_psrc_a,
  output logic [PW-1:0] out_psrc_b,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold,
  output logic          out_has_dst,
  input  logic          free_valid,
  input  logic [PW-1:0] free_preg
);
  logic [PW-1:0] fl_head;
  logic [CW-1:0] free_cnt;
  logic [PW-1:0] map_old;
  logic          stall, fire, alloc;

  assign stall     = in_has_dst && (free_cnt == '0);
  assign out_valid = in_valid && !stall;
  assign in_ready  = out_ready && !stall;
  assign fire      = in_valid && in_ready;
  assign alloc     = fire && in_has_dst;

  rename_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) i_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (in_src_a),
    .rd_b_idx (in_src_b),
    .rd_d_idx (in_dst),
    .rd_a_phys(out_psrc_a),
    .rd_b_phys(out_psrc_b),
    .rd_d_phys(map_old),
    .wr_en    (alloc),
    .wr_idx   (in_dst),
    .wr_phys  (fl_head)
  );

  rename_free_list #(.BASE(ARCH_REGS), .DEPTH(FL_DEPTH), .PW(PW)) i_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (free_valid),
    .push_data(free_preg),
    .pop      (alloc),
    .pop_data (fl_head),
    .count    (free_cnt)
  );

  assign out_pdst    = in_has_dst ? fl_head : '0;
  assign out_pold    = in_has_dst ? map_old : '0;
  assign out_has_dst = in_has_dst;
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 4,
  parameter int unsigned DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_has_dst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_pdst,
  input logic [PW-1:0] out_pold,
  input logic          free_valid,
  input logic [CW-1:0] free_cnt,
  input logic          alloc
);
  // R6: an allocating instruction never passes an empty pool
  a_r6_stall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_has_dst && free_cnt == '0) |-> (!in_ready && !out_valid));

  // R8: acceptance requires downstream readiness
  a_r8_ready_needs_downstream: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  // R7: pool occupancy follows returns and allocations
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (free_cnt == $past(free_cnt) + {{(CW-1){1'b0}}, $past(free_valid)}
                                          - {{(CW-1){1'b0}}, $past(alloc)}));

  // R7: no return into a full pool unless one leaves that cycle
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> ((free_cnt != CW'(DEPTH)) || alloc));

  // R3: new destination differs from the mapping it replaces
  a_r3_fresh_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_has_dst) |-> (out_pdst != out_pold));

  // R5: no-destination instructions never allocate
  a_r5_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    !in_has_dst |-> !alloc);
endmodule

bind rename_unit rename_unit_chk #(.PW(PW), .CW(CW), .DEPTH(FL_DEPTH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_has_dst(in_has_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pdst  (out_pdst),
  .out_pold  (out_pold),
  .free_valid(free_valid),
  .free_cnt  (free_cnt),
  .alloc     (alloc)
);

// File: tb/test_rename_unit.sv
module test_rename_unit;
  localparam int ARCH = 8;
  localparam int PHYS = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_dst = 0, out_ready = 1, free_valid = 0;
  logic [2:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic [3:0] free_preg = 0;
  logic in_ready, out_valid, out_has_dst;
  logic [3:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

  always #5 clk = ~clk;

  rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) i_rename_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_has_dst(in_has_dst),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
    .out_pdst(out_pdst), .out_pold(out_pold), .out_has_dst(out_has_dst),
    .free_valid(free_valid), .free_preg(free_preg)
  );

  typedef struct {
    bit    fire;
    bit    ovalid;
    int    pa, pb, pd, po;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    model_map[ARCH];
  int    model_free[$];
  int    n_checks = 0, n_fail = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts its result
  task automatic drive(input bit v, input int sa, input int sb, input int d, input bit hd,
                       input bit ordy, input bit fv, input int fp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    in_valid = v; in_src_a = 3'(sa); in_src_b = 3'(sb); in_dst = 3'(d);
    in_has_dst = hd; out_ready = ordy; free_valid = fv; free_preg = 4'(fp);
    it.tag = tag;
    it.ovalid = v && (!hd || model_free.size() > 0);
    it.fire = it.ovalid && ordy;
    it.pa = model_map[sa];
    it.pb = model_map[sb];
    it.pd = 0;
    it.po = 0;
    if (hd && model_free.size() > 0) begin
      it.pd = model_free[0];
      it.po = model_map[d];
    end
    if (it.fire && hd) begin
      void'(model_free.pop_front());
      model_map[d] = it.pd;
    end
    if (fv) model_free.push_back(fp);
    if (v) exp_q.push_back(it);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 1, 0, 0, "idle");
  endtask

  // monitor: compares the design against the queued predictions mid-cycle
  always @(negedge clk) begin
    if (rst_n && in_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R8 unexpected offer actual=1 expected=0");
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.tag, "out_valid", int'(out_valid), int'(e.ovalid));
        chk(e.tag, "in_ready", int'(in_ready), int'(e.fire));
        if (e.ovalid) begin
          chk(e.tag, "psrc_a", int'(out_psrc_a), e.pa);
          chk(e.tag, "psrc_b", int'(out_psrc_b), e.pb);
          chk(e.tag, "pdst", int'(out_pdst), e.pd);
          chk(e.tag, "pold", int'(out_pold), e.po);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < ARCH; i++) model_map[i] = i;
    for (int p = ARCH; p < PHYS; p++) model_free.push_back(p);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R8", "idle out_valid", int'(out_valid), 0);
    chk("R6", "idle in_ready", int'(in_ready), 1);

    // R1: identity map after reset
    for (int i = 0; i < ARCH; i++) drive(1, i, ARCH - 1 - i, 0, 0, 1, 0, 0, "R1");
    // R9 with R3/R4: the worked sequence, pool head 8,9,10
    drive(1, 2, 2, 1, 1, 1, 0, 0, "R9");
    drive(1, 0, 0, 2, 1, 1, 0, 0, "R9");
    drive(1, 2, 2, 1, 1, 1, 0, 0, "R9");
    drive(1, 1, 2, 0, 0, 1, 0, 0, "R3");
    // R2: source equals destination
    drive(1, 3, 3, 3, 1, 1, 0, 0, "R2");
    drive(1, 3, 4, 0, 0, 1, 0, 0, "R2");
    // R5: no destination leaves pool and table alone
    drive(1, 5, 6, 5, 0, 1, 0, 0, "R5");
    drive(1, 5, 5, 5, 1, 1, 0, 0, "R5");
    // R8: back-pressure holds everything
    drive(1, 1, 3, 6, 1, 0, 0, 0, "R8");
    drive(1, 1, 3, 6, 1, 0, 0, 0, "R8");
    drive(1, 1, 3, 6, 1, 1, 0, 0, "R8");
    drive(1, 6, 6, 0, 0, 1, 0, 0, "R8");
    // drain the remaining pool (14, 15)
    drive(1, 0, 1, 4, 1, 1, 0, 0, "R3");
    drive(1, 4, 0, 7, 1, 1, 0, 0, "R3");
    // R6: empty pool stalls allocators, passes non-allocators
    drive(1, 2, 3, 2, 1, 1, 0, 0, "R6");
    drive(1, 2, 3, 0, 0, 1, 0, 0, "R6");
    // R7: return during a stall does not release it this cycle
    drive(1, 2, 3, 2, 1, 1, 1, 1, "R7");
    drive(1, 2, 3, 2, 1, 1, 0, 0, "R7");
    drive(1, 2, 2, 0, 0, 1, 0, 0, "R7");
    // R7: return two, then allocate and return together
    drive(0, 0, 0, 0, 0, 1, 1, 2, "R7");
    drive(1, 0, 0, 0, 1, 1, 1, 8, "R7");
    drive(1, 1, 1, 1, 1, 1, 0, 0, "R7");
    drive(1, 0, 1, 3, 1, 1, 0, 0, "R7");
    drive(1, 0, 1, 3, 1, 1, 0, 0, "R6");
    idle();
    idle();
    chk("R8", "pending predictions", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule